// File: doc/BRIEF.md
# Chained Vector Execution Unit

This block is the arithmetic core of a register-to-register vector engine. It holds eight vector registers of 64 elements of 64 bits, a vector length register and a 64-bit element mask, and drives two fully pipelined integer units: an adder (latency 2) and a multiplier (latency 4). Commands arrive on a valid/ready port carrying an opcode, a destination, two vector sources or one vector source and a 64-bit scalar that is broadcast to every element, plus a flag that restricts the write to elements whose mask bit is set.

Each unit takes one element per cycle. When a command reads a register that the other unit is still producing, the command starts at once and reads each element as soon as that element has been written. A multiply feeding an add therefore finishes in about one vector length plus both latencies, not two vector lengths. A command whose unit is free and that causes no register or mask conflict is accepted in the cycle it is presented. Each unit raises a one-cycle done pulse after writing its last element. Results are observed through a combinational element read port.

Back-pressure: a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` depends on the presented command and on the units' state. A sender that sees `cmd_ready` low keeps the command stable and holds `cmd_valid` high until it is taken, or drops it.

Top module: `vec_chain_unit`

## Requirements
- R1: After reset `cmd_ready` is high, `vl_out` is 64, `mask_out` is all ones, `done` is 0 and every register element reads 0.
- R2: Opcode 6 sets the vector length from the scalar: 0 becomes 1, values above 64 become 64, other values are kept. It is accepted only when both units are idle.
- R3: Adder opcodes write element i for every i below the vector length, modulo 2^64. Opcode 0 writes va[i]+vb[i], opcode 1 writes va[i]+scalar, and opcode 4 writes scalar+i. Elements at or above the vector length keep their value.
- R4: Opcode 2 writes the low 64 bits of va[i]*vb[i] and opcode 3 writes the low 64 bits of va[i]*scalar.
- R5: Opcode 5 sets mask bit i to 1 when va[i] is zero and to 0 otherwise, for i below the vector length. It clears the mask bits at or above the vector length.
- R6: With `cmd_masked` high, elements whose mask bit is 0 keep their old value.
- R7: A command that reads a register the other unit is writing starts on element 0 once that element is written. For an add of a multiply result taken one cycle after the multiply, `done[0]` is seen after the edge that lies VL+5 edges after the multiply's accepting edge.
- R8: `cmd_ready` is high when the target unit is idle and no conflict exists, so an adder command and a multiplier command are taken on consecutive edges. It is low while the target unit is busy.
- R9: `done[0]` (adder) and `done[1]` (multiplier) pulse for one cycle, after the edge that lies latency+VL-1 edges after the accepting edge.
- R10: A command is held off while the other unit writes its destination (write after write) or still reads it (write after read).
- R11: A held command is taken once its conflict clears and then executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this edge |
| cmd_op | input | 3 | Opcode (0..6) |
| cmd_masked | input | 1 | Write only elements whose mask bit is set |
| cmd_vd | input | 3 | Destination register |
| cmd_va | input | 3 | First source register |
| cmd_vb | input | 3 | Second source register |
| cmd_scalar | input | 64 | Broadcast operand or length value |
| done | output | 2 | Last-element pulse per unit (bit 0 adder, bit 1 multiplier) |
| rd_reg | input | 3 | Read port register select |
| rd_idx | input | 6 | Read port element select |
| rd_data | output | 64 | Selected element |
| vl_out | output | 7 | Current vector length |
| mask_out | output | 64 | Current element mask |

## Verification
The hardest situation to reach from the ports is a consumer that runs in lock-step behind a producer. It only occurs when a multiply is taken and a dependent add follows on the very next edge, so the bench presents the add on the falling edge straight after the multiply is accepted. It checks that the add is taken at once, that its done pulse lands exactly VL+5 edges after the multiply, and that the last chained element holds the correct sum. Conflicts are produced the same way: a second command is presented while a multiply is in flight, and the bench watches `cmd_ready` before dropping or holding that command.

// File: rtl/vcu_pkg.sv
`timescale 1ns/1ps
package vcu_pkg;
  typedef enum logic [2:0] {
    OP_VADD  = 3'd0,
    OP_SADD  = 3'd1,
    OP_VMUL  = 3'd2,
    OP_SMUL  = 3'd3,
    OP_RAMP  = 3'd4,
    OP_TESTZ = 3'd5,
    OP_SETVL = 3'd6,
    OP_NOP   = 3'd7
  } op_t;

  function automatic logic op_is_mul(op_t op);
    return (op == OP_VMUL) || (op == OP_SMUL);
  endfunction

  function automatic logic op_uses_a(op_t op);
    return (op != OP_RAMP) && (op != OP_SETVL) && (op != OP_NOP);
  endfunction

  function automatic logic op_uses_b(op_t op);
    return (op == OP_VADD) || (op == OP_VMUL);
  endfunction

  function automatic logic op_writes_reg(op_t op);
    return (op == OP_VADD) || (op == OP_SADD) || (op == OP_VMUL) ||
           (op == OP_SMUL) || (op == OP_RAMP);
  endfunction

  function automatic logic op_runs(op_t op);
    return (op != OP_SETVL) && (op != OP_NOP);
  endfunction
endpackage

// File: rtl/vcu_func_unit.sv
`timescale 1ns/1ps
// One pipelined element unit. LAT must be at least 2.
module vcu_func_unit
  import vcu_pkg::*;
#(
  parameter int DW     = 64,
  parameter int NELEM  = 64,
  parameter int RW     = 3,
  parameter int LAT    = 2,
  parameter bit IS_MUL = 1'b0,
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_t              s_op,
  input  logic [RW-1:0]    s_vd,
  input  logic [RW-1:0]    s_va,
  input  logic [RW-1:0]    s_vb,
  input  logic [DW-1:0]    s_scalar,
  input  logic             s_masked,
  input  logic [LW-1:0]    vl,
  input  logic [NELEM-1:0] mask,
  input  logic [DW-1:0]    a_data,
  input  logic [DW-1:0]    b_data,
  input  logic             o_busy,
  input  logic             o_wrf,
  input  logic [RW-1:0]    o_vd,
  input  logic [LW-1:0]    o_wcnt,
  output logic             busy,
  output logic             wrf,
  output logic             test,
  output logic             masked,
  output logic             uses_a,
  output logic             uses_b,
  output logic [RW-1:0]    vd,
  output logic [RW-1:0]    va,
  output logic [RW-1:0]    vb,
  output logic [LW-1:0]    wcnt,
  output logic [IW-1:0]    ridx,
  output logic             wen,
  output logic             wmask,
  output logic [IW-1:0]    widx,
  output logic [DW-1:0]    wdata,
  output logic             done
);
  localparam int NS = LAT - 1;

  logic          busy_q, msk_q, done_q;
  op_t           op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [DW-1:0] sc_q;
  logic [LW-1:0] icnt_q, wcnt_q;

  logic          p_v  [NS];
  logic          p_we [NS];
  logic [IW-1:0] p_idx[NS];
  logic [DW-1:0] p_d  [NS];

  logic          a_ok, b_ok, go, keep, last;
  logic [DW-1:0] y, res;

  // An operand is ready when the other unit is not producing it,
  // or has already written the element about to be read.
  always_comb begin
    a_ok = !op_uses_a(op_q) || !(o_busy && o_wrf && (o_vd == va_q)) || (o_wcnt > icnt_q);
    b_ok = !op_uses_b(op_q) || !(o_busy && o_wrf && (o_vd == vb_q)) || (o_wcnt > icnt_q);
    go   = busy_q && (icnt_q < vl) && a_ok && b_ok;
    ridx = icnt_q[IW-1:0];
    y    = op_uses_b(op_q) ? b_data : sc_q;
    keep = !msk_q || (op_q == OP_TESTZ) || mask[ridx];
    last = p_v[NS-1] && ((wcnt_q + LW'(1)) == vl);
  end

  generate
    if (IS_MUL) begin : g_mul
      assign res = a_data * y;
    end else begin : g_add
      always_comb begin
        case (op_q)
          OP_RAMP:  res = sc_q + DW'(icnt_q);
          OP_TESTZ: res = {{(DW-1){1'b0}}, (a_data == '0)};
          default:  res = a_data + y;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NOP;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      sc_q   <= '0;
      msk_q  <= 1'b0;
      icnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        op_q   <= s_op;
        vd_q   <= s_vd;
        va_q   <= s_va;
        vb_q   <= s_vb;
        sc_q   <= s_scalar;
        msk_q  <= s_masked;
        icnt_q <= '0;
        wcnt_q <= '0;
      end else if (busy_q) begin
        if (go) icnt_q <= icnt_q + LW'(1);
        if (p_v[NS-1]) wcnt_q <= wcnt_q + LW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) begin
        p_v[k]   <= 1'b0;
        p_we[k]  <= 1'b0;
        p_idx[k] <= '0;
        p_d[k]   <= '0;
      end
    end else begin
      p_v[0]   <= go;
      p_we[0]  <= keep;
      p_idx[0] <= ridx;
      p_d[0]   <= res;
      for (int k = 1; k < NS; k++) begin
        p_v[k]   <= p_v[k-1];
        p_we[k]  <= p_we[k-1];
        p_idx[k] <= p_idx[k-1];
        p_d[k]   <= p_d[k-1];
      end
    end
  end

  assign busy   = busy_q;
  assign wrf    = op_writes_reg(op_q);
  assign test   = (op_q == OP_TESTZ);
  assign masked = msk_q;
  assign uses_a = op_uses_a(op_q);
  assign uses_b = op_uses_b(op_q);
  assign vd     = vd_q;
  assign va     = va_q;
  assign vb     = vb_q;
  assign wcnt   = wcnt_q;
  assign wen    = p_v[NS-1] && p_we[NS-1];
  assign wmask  = test;
  assign widx   = p_idx[NS-1];
  assign wdata  = p_d[NS-1];
  assign done   = done_q;
endmodule

// File: rtl/vec_chain_unit.sv
`timescale 1ns/1ps
module vec_chain_unit
  import vcu_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int NELEM   = 64,
  parameter int DW      = 64,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_masked,
  input  logic [RW-1:0]    cmd_vd,
  input  logic [RW-1:0]    cmd_va,
  input  logic [RW-1:0]    cmd_vb,
  input  logic [DW-1:0]    cmd_scalar,
  output logic [1:0]       done,
  input  logic [RW-1:0]    rd_reg,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [LW-1:0]    vl_out,
  output logic [NELEM-1:0] mask_out
);
  logic [DW-1:0]    rf [NREG][NELEM];
  logic [LW-1:0]    vl_q;
  logic [NELEM-1:0] mask_q;

  // Per-unit status: index 0 adder, index 1 multiplier.
  wire [1:0]         u_busy, u_wrf, u_test, u_msk, u_ua, u_ub, u_wen, u_wm, u_done, u_start;
  wire [1:0][RW-1:0] u_vd, u_va, u_vb;
  wire [1:0][LW-1:0] u_wcnt;
  wire [1:0][IW-1:0] u_ridx, u_widx;
  wire [1:0][DW-1:0] u_wd, u_ad, u_bd;

  op_t  op;
  logic tgt, oth, waw, war, mconf, rdy, acc;

  assign op  = op_t'(cmd_op);
  assign tgt = op_is_mul(op);
  assign oth = ~tgt;

  always_comb begin
    waw   = u_busy[oth] && u_wrf[oth] && (u_vd[oth] == cmd_vd);
    war   = u_busy[oth] && ((u_ua[oth] && (u_va[oth] == cmd_vd)) ||
                            (u_ub[oth] && (u_vb[oth] == cmd_vd)));
    mconf = u_busy[oth] && ((cmd_masked && u_test[oth]) ||
                            ((op == OP_TESTZ) && u_msk[oth]));
    case (op)
      OP_SETVL: rdy = (u_busy == 2'b00);
      OP_NOP:   rdy = 1'b1;
      default:  rdy = !u_busy[tgt] && !(op_writes_reg(op) && (waw || war)) && !mconf;
    endcase
    acc = cmd_valid && rdy;
  end

  generate
    for (genvar u = 0; u < 2; u++) begin : g_unit
      assign u_start[u] = acc && op_runs(op) && (tgt == u[0]);
      assign u_ad[u]    = rf[u_va[u]][u_ridx[u]];
      assign u_bd[u]    = rf[u_vb[u]][u_ridx[u]];

      vcu_func_unit #(
        .DW(DW), .NELEM(NELEM), .RW(RW),
        .LAT((u == 1) ? MUL_LAT : ADD_LAT),
        .IS_MUL(u == 1)
      ) u_fu (
        .clk(clk), .rst_n(rst_n), .start(u_start[u]),
        .s_op(op), .s_vd(cmd_vd), .s_va(cmd_va), .s_vb(cmd_vb),
        .s_scalar(cmd_scalar), .s_masked(cmd_masked),
        .vl(vl_q), .mask(mask_q), .a_data(u_ad[u]), .b_data(u_bd[u]),
        .o_busy(u_busy[1-u]), .o_wrf(u_wrf[1-u]), .o_vd(u_vd[1-u]), .o_wcnt(u_wcnt[1-u]),
        .busy(u_busy[u]), .wrf(u_wrf[u]), .test(u_test[u]), .masked(u_msk[u]),
        .uses_a(u_ua[u]), .uses_b(u_ub[u]),
        .vd(u_vd[u]), .va(u_va[u]), .vb(u_vb[u]), .wcnt(u_wcnt[u]),
        .ridx(u_ridx[u]), .wen(u_wen[u]), .wmask(u_wm[u]),
        .widx(u_widx[u]), .wdata(u_wd[u]), .done(u_done[u])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < NELEM; e++)
          rf[r][e] <= '0;
    end else begin
      for (int u = 0; u < 2; u++)
        if (u_wen[u] && !u_wm[u]) rf[u_vd[u]][u_widx[u]] <= u_wd[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= LW'(NELEM);
      mask_q <= '1;
    end else begin
      if (acc && (op == OP_SETVL)) begin
        if (cmd_scalar == '0)                   vl_q <= LW'(1);
        else if (cmd_scalar > DW'(NELEM))       vl_q <= LW'(NELEM);
        else                                    vl_q <= cmd_scalar[LW-1:0];
      end
      if (u_start[0] && (op == OP_TESTZ)) mask_q <= '0;
      else if (u_wen[0] && u_wm[0])       mask_q[u_widx[0]] <= u_wd[0][0];
    end
  end

  assign cmd_ready = rdy;
  assign done      = u_done;
  assign rd_data   = rf[rd_reg][rd_idx];
  assign vl_out    = vl_q;
  assign mask_out  = mask_q;
endmodule

module vcu_checker
  import vcu_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int RW    = 3,
  parameter int IW    = 6,
  parameter int LW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [LW-1:0]    vl_out,
  input logic [1:0]       u_busy,
  input logic [1:0]       u_done,
  input logic [1:0]       u_wen,
  input logic [1:0]       u_wm,
  input logic [1:0][RW-1:0] u_vd,
  input logic [1:0][IW-1:0] u_widx
);
  assert_vl_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_out != '0) && (vl_out <= LW'(NELEM)));

  assert_setvl_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == OP_SETVL)) |-> (u_busy == 2'b00));

  assert_no_dual_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (u_wen[0] && u_wen[1] && !u_wm[0] && !u_wm[1]) |-> (u_vd[0] != u_vd[1]));

  generate
    for (genvar k = 0; k < 2; k++) begin : g_chk
      assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        u_done[k] |-> (!u_busy[k] && $past(u_busy[k])));
      assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        u_done[k] |=> !u_done[k]);
      assert_write_below_vl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        u_wen[k] |-> (LW'(u_widx[k]) < vl_out));
    end
  endgenerate
endmodule

bind vec_chain_unit vcu_checker #(.NELEM(NELEM), .RW(RW), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .vl_out(vl_out), .u_busy(u_busy), .u_done(u_done),
  .u_wen(u_wen), .u_wm(u_wm), .u_vd(u_vd), .u_widx(u_widx)
);

// File: tb/sim_vec_chain_unit.sv
`timescale 1ns/1ps
module sim_vec_chain_unit;
  localparam logic [2:0] VADD = 3'd0, SADD = 3'd1, VMUL = 3'd2, SMUL = 3'd3,
                         RAMP = 3'd4, TESTZ = 3'd5, SETVL = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_masked = 1'b0;
  logic [2:0]  cmd_op = 3'd0, cmd_vd = 3'd0, cmd_va = 3'd0, cmd_vb = 3'd0;
  logic [63:0] cmd_scalar = '0;
  logic        cmd_ready;
  logic [1:0]  done;
  logic [2:0]  rd_reg = 3'd0;
  logic [5:0]  rd_idx = 6'd0;
  logic [63:0] rd_data, mask_out;
  logic [6:0]  vl_out;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vec_chain_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_masked(cmd_masked), .cmd_vd(cmd_vd), .cmd_va(cmd_va),
    .cmd_vb(cmd_vb), .cmd_scalar(cmd_scalar), .done(done), .rd_reg(rd_reg),
    .rd_idx(rd_idx), .rd_data(rd_data), .vl_out(vl_out), .mask_out(mask_out)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op, vd, va, vb;
    logic        m;
    logic [63:0] sc;
    logic [2:0]  cr;
    logic [5:0]  ci;
    logic [63:0] ex;
  } row_t;

  localparam row_t ROWS [12] = '{
    '{4'd3, RAMP,  3'd1, 3'd0, 3'd0, 1'b0, 64'd10, 3'd1, 6'd5,  64'd15},  // R3 ramp
    '{4'd3, RAMP,  3'd2, 3'd0, 3'd0, 1'b0, 64'd0,  3'd2, 6'd63, 64'd63},  // R3 last element
    '{4'd3, VADD,  3'd3, 3'd1, 3'd2, 1'b0, 64'd0,  3'd3, 6'd7,  64'd24},  // R3 vector add
    '{4'd4, SMUL,  3'd4, 3'd1, 3'd0, 1'b0, 64'd3,  3'd4, 6'd2,  64'd36},  // R4 scaled
    '{4'd4, VMUL,  3'd5, 3'd1, 3'd2, 1'b0, 64'd0,  3'd5, 6'd4,  64'd56},  // R4 vector mul
    '{4'd3, SADD,  3'd6, 3'd2, 3'd0, 1'b0, '1,     3'd6, 6'd0,  '1},      // R3 wrap
    '{4'd4, SMUL,  3'd7, 3'd1, 3'd0, 1'b0, 64'h8000_0000_0000_0000, 3'd7, 6'd1, 64'h8000_0000_0000_0000}, // R4 low bits
    '{4'd2, SETVL, 3'd0, 3'd0, 3'd0, 1'b0, 64'd8,  3'd1, 6'd0,  64'd10},  // R2
    '{4'd5, TESTZ, 3'd0, 3'd2, 3'd0, 1'b0, 64'd0,  3'd2, 6'd0,  64'd0},   // R5
    '{4'd6, VADD,  3'd1, 3'd1, 3'd1, 1'b1, 64'd0,  3'd1, 6'd0,  64'd20},  // R6 enabled element
    '{4'd6, SADD,  3'd0, 3'd2, 3'd0, 1'b0, 64'd0,  3'd1, 6'd1,  64'd11},  // R6 masked-off element kept
    '{4'd3, SADD,  3'd0, 3'd2, 3'd0, 1'b0, 64'd100, 3'd0, 6'd8, 64'd0}    // R3 beyond length untouched
  };

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, got, exp);
    end
  endtask

  task automatic put(input logic [2:0] op, input logic [2:0] vd, input logic [2:0] va,
                     input logic [2:0] vb, input logic m, input logic [63:0] sc);
    cmd_op = op; cmd_vd = vd; cmd_va = va; cmd_vb = vb;
    cmd_masked = m; cmd_scalar = sc; cmd_valid = 1'b1;
    #1;
  endtask

  task automatic take();
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drop_and_wait(input int n);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input string rq, input logic [2:0] r, input logic [5:0] i,
                      input logic [63:0] exp);
    rd_reg = r; rd_idx = i; #1;
    chk(rq, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_done(input int bitn, input int start_cnt, output int cnt);
    cnt = start_cnt;
    while (!done[bitn]) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int cnt;
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk("R1 ready", 64'(cmd_ready), 64'd1);
    chk("R1 vl", 64'(vl_out), 64'd64);
    chk("R1 mask", mask_out, '1);
    chk("R1 done", 64'(done), 64'd0);
    peek("R1 element", 3'd3, 6'd0, 64'd0);

    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      put(ROWS[k].op, ROWS[k].vd, ROWS[k].va, ROWS[k].vb, ROWS[k].m, ROWS[k].sc);
      take();
      repeat (80) @(negedge clk);
      peek($sformatf("R%0d row %0d", ROWS[k].rq, k), ROWS[k].cr, ROWS[k].ci, ROWS[k].ex);
      @(negedge clk);
    end

    // R5 mask from the table's test on v2 with length 8, then zero result
    chk("R5 mask bit0", mask_out, 64'h1);
    put(TESTZ, 3'd0, 3'd0, 3'd0, 1'b0, 64'd0); take();
    repeat (20) @(negedge clk); #1;
    chk("R5 no zeros", mask_out, 64'h0);

    // R2 clamping
    @(negedge clk);
    put(SETVL, 3'd0, 3'd0, 3'd0, 1'b0, 64'd0); take(); #1;
    chk("R2 zero to one", 64'(vl_out), 64'd1);
    put(SETVL, 3'd0, 3'd0, 3'd0, 1'b0, 64'd200); take(); #1;
    chk("R2 saturate", 64'(vl_out), 64'd64);
    put(SETVL, 3'd0, 3'd0, 3'd0, 1'b0, 64'd4); take(); #1;
    chk("R2 set four", 64'(vl_out), 64'd4);

    // R9 adder done timing (2+4-1) and pulse width
    @(negedge clk);
    put(SADD, 3'd7, 3'd2, 3'd0, 1'b0, 64'd1); take();
    wait_done(0, 0, cnt);
    chk("R9 adder done edge", 64'(cnt), 64'd5);
    @(negedge clk); #1;
    chk("R9 one cycle", 64'(done[0]), 64'd0);
    peek("R3 add len4", 3'd7, 6'd3, 64'd4);
    peek("R3 beyond len", 3'd7, 6'd4, 64'd0);

    // R9 multiplier done timing (4+4-1)
    @(negedge clk);
    put(SMUL, 3'd3, 3'd2, 3'd0, 1'b0, 64'd5); take();
    wait_done(1, 0, cnt);
    chk("R9 mul done edge", 64'(cnt), 64'd7);
    peek("R4 mul len4", 3'd3, 6'd3, 64'd15);

    // R7 chained multiply then add, VL 64
    @(negedge clk);
    put(SETVL, 3'd0, 3'd0, 3'd0, 1'b0, 64'd64); take();
    put(VMUL, 3'd5, 3'd1, 3'd2, 1'b0, 64'd0); take();
    put(VADD, 3'd6, 3'd5, 3'd1, 1'b0, 64'd0);
    chk("R8 next-cycle issue", 64'(cmd_ready), 64'd1);
    take();
    wait_done(0, 1, cnt);
    chk("R7 chain done edge", 64'(cnt), 64'd69);
    repeat (10) @(negedge clk);
    peek("R7 chained last", 3'd6, 6'd63, 64'd4672);

    // R8 busy unit holds off a second multiply
    @(negedge clk);
    put(VMUL, 3'd5, 3'd1, 3'd2, 1'b0, 64'd0); take();
    put(SMUL, 3'd4, 3'd1, 3'd0, 1'b0, 64'd2);
    chk("R8 busy stall", 64'(cmd_ready), 64'd0);
    drop_and_wait(80);

    // R10 write after write
    put(VMUL, 3'd5, 3'd1, 3'd2, 1'b0, 64'd0); take();
    put(SADD, 3'd5, 3'd0, 3'd0, 1'b0, 64'd1);
    chk("R10 waw stall", 64'(cmd_ready), 64'd0);
    drop_and_wait(80);

    // R10 write after read, and an unrelated add still goes (R8)
    put(VMUL, 3'd5, 3'd1, 3'd2, 1'b0, 64'd0); take();
    put(SADD, 3'd2, 3'd0, 3'd0, 1'b0, 64'd1);
    chk("R10 war stall", 64'(cmd_ready), 64'd0);
    put(SADD, 3'd6, 3'd0, 3'd0, 1'b0, 64'd1);
    chk("R8 free unit", 64'(cmd_ready), 64'd1);
    take();
    repeat (80) @(negedge clk);
    peek("R10 v2 untouched", 3'd2, 6'd10, 64'd10);

    // R11 held command taken once the multiplier frees up
    put(VMUL, 3'd3, 3'd2, 3'd2, 1'b0, 64'd0); take();
    put(SMUL, 3'd4, 3'd2, 3'd0, 1'b0, 64'd2);
    r = cmd_ready;
    chk("R11 held first", 64'(r), 64'd0);
    take();
    repeat (80) @(negedge clk);
    peek("R11 held result", 3'd4, 6'd10, 64'd20);
    peek("R4 square", 3'd3, 6'd10, 64'd100);

    finish_run();
  end
endmodule